// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block stands between a MAC's transmit-enable line and the 10BASE-T line driver. It stops a transmitter that has locked up and would otherwise send a frame far beyond the legal maximum length. A run-length timer counts every cycle in which transmit enable stays high. If the run reaches its limit, the block trips and forces its gated transmit enable low. This limit is about 85 ms in a real system.

Once tripped, the block keeps the gate closed for as long as the incoming transmit enable stays asserted. Lowering transmit enable is not enough to reopen the gate. The line must then stay quiet for a separate unjab interval, about 500 ms in a real system, before transmission is allowed again. If transmit enable returns during that quiet period, the quiet count starts over.

The watchdog acts only when the 10BASE-T mode input is high. In any other mode, transmit enable passes straight through and both timers are held at zero. Both limits are parameters counted in clock cycles. A sticky flag records that a trip happened, and a clear strobe resets that flag.

The controller has four states:
- ST_IDLE: enabled, line quiet.
- ST_SEND: enabled, frame in progress.
- ST_JABBED: tripped, transmit enable still high.
- ST_QUIET: tripped, transmit enable low, counting the unjab interval.

The transitions are:
- ST_IDLE to ST_SEND when transmit enable goes high.
- ST_SEND to ST_IDLE when transmit enable goes low.
- ST_IDLE or ST_SEND to ST_JABBED when the run timer hits its limit.
- ST_JABBED to ST_QUIET when transmit enable goes low.
- ST_QUIET to ST_JABBED when transmit enable rises again.
- ST_JABBED or ST_QUIET to ST_IDLE when the quiet timer hits its limit.
- Any state to ST_IDLE when the mode input is low.

Top module: `jabber_guard`

## Requirements
- R1: With mode high and `tx_en_i` high for RUN_LIM consecutive clock edges, `tx_en_o` follows the input for those RUN_LIM cycles. From the cycle after the RUN_LIM-th edge, `tx_en_o` is 0 and `jab_active_o` is 1.
- R2: A low `tx_en_i` sampled at any edge before the limit restarts the run count. A run of fewer than RUN_LIM high edges never trips.
- R3: While `jab_active_o` is 1 and `tx_en_i` is held high, `tx_en_o` stays 0 and `jab_active_o` stays 1, however long the input is held.
- R4: After a trip, `jab_active_o` is released, and `tx_en_o` follows the input again, only after QUIET_LIM consecutive edges with `tx_en_i` low. Through the first QUIET_LIM-1 of those edges the block stays tripped.
- R5: If `tx_en_i` rises before the quiet interval completes, the block stays tripped and the quiet count starts over. A full QUIET_LIM low edges is then needed again.
- R6: With mode low, `tx_en_o` equals `tx_en_i` in the same cycle. From the next edge on, both timers are zero and `jab_active_o` is 0, including when mode drops while the block is tripped.
- R7: `jab_sticky_o` is set at the edge where the block trips and stays set. A one-cycle `clr_sticky_i` pulse clears it at the next edge. A trip at the same edge as a clear leaves the flag set.
- R8: Synchronous active-high reset gives `jab_active_o` = 0, `jab_sticky_o` = 0 and both timers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| mode_10bt_i | input | 1 | 1 = 10BASE-T mode, watchdog active |
| clr_sticky_i | input | 1 | Clear strobe for the sticky trip flag |
| tx_en_o | output | 1 | Gated transmit enable to the line driver |
| jab_active_o | output | 1 | High from trip until re-enable |
| jab_sticky_o | output | 1 | Sticky record that a trip happened |

## Verification
The gate on `tx_en_o` is combinational from the input, but its blocking term comes from the state register. A trip or a release therefore shows on `tx_en_o` and `jab_active_o` one cycle after the edge that completes the count: after edge RUN_LIM for a trip, and after edge QUIET_LIM for a release. The sticky flag follows the same one-edge latency. The bench drives every input on the falling edge, lets the logic settle for a short delay, and checks the outputs there. Each check therefore sees the state left by the previous rising edge combined with the input just applied. The expected values come from counting rising edges against the two limits.

// File: rtl/jab_pkg.sv
package jab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_JABBED = 2'd2,
        ST_QUIET  = 2'd3
    } jab_state_t;
endpackage

// File: rtl/jab_timer.sv
// Consecutive-cycle counter: counts while inc is high, clears otherwise.
// hit marks the cycle whose edge completes LIMIT counted cycles.
module jab_timer #(
    parameter int LIMIT = 16,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          hit
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    assign hit = inc && (count == LAST);

    always_ff @(posedge clk) begin
        if (rst || !inc || hit) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
    import jab_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode,
    input  logic       tx_en,
    input  logic       run_hit,
    input  logic       quiet_hit,
    output jab_state_t state,
    output logic       run_inc,
    output logic       quiet_inc,
    output logic       blocked,
    output logic       trip
);
    jab_state_t nxt;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!mode) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run_hit)    nxt = ST_JABBED;
                    else if (tx_en) nxt = ST_SEND;
                end
                ST_SEND: begin
                    if (run_hit)     nxt = ST_JABBED;
                    else if (!tx_en) nxt = ST_IDLE;
                end
                ST_JABBED: begin
                    if (quiet_hit)   nxt = ST_IDLE;
                    else if (!tx_en) nxt = ST_QUIET;
                end
                ST_QUIET: begin
                    if (quiet_hit)  nxt = ST_IDLE;
                    else if (tx_en) nxt = ST_JABBED;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // outputs
    always_comb begin
        blocked   = (state == ST_JABBED) || (state == ST_QUIET);
        run_inc   = mode && tx_en && !blocked;
        quiet_inc = mode && !tx_en && blocked;
        trip      = mode && run_hit && !blocked;
    end
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
    import jab_pkg::*;
#(
    parameter int RUN_LIM   = 850_000,
    parameter int QUIET_LIM = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en_i,
    input  logic mode_10bt_i,
    input  logic clr_sticky_i,
    output logic tx_en_o,
    output logic jab_active_o,
    output logic jab_sticky_o
);
    localparam int RCW = $clog2(RUN_LIM + 1);
    localparam int QCW = $clog2(QUIET_LIM + 1);

    logic [RCW-1:0] run_cnt;
    logic [QCW-1:0] quiet_cnt;
    logic           run_inc, quiet_inc, run_hit, quiet_hit;
    logic           blocked, trip;
    jab_state_t     state;

    jab_timer #(.LIMIT(RUN_LIM), .CW(RCW)) u_run (
        .clk(clk), .rst(rst), .inc(run_inc), .count(run_cnt), .hit(run_hit)
    );

    jab_timer #(.LIMIT(QUIET_LIM), .CW(QCW)) u_quiet (
        .clk(clk), .rst(rst), .inc(quiet_inc), .count(quiet_cnt), .hit(quiet_hit)
    );

    jab_fsm u_fsm (
        .clk(clk), .rst(rst), .mode(mode_10bt_i), .tx_en(tx_en_i),
        .run_hit(run_hit), .quiet_hit(quiet_hit), .state(state),
        .run_inc(run_inc), .quiet_inc(quiet_inc), .blocked(blocked), .trip(trip)
    );

    // sticky trip record; a trip wins over a clear at the same edge
    always_ff @(posedge clk) begin
        if (rst)               jab_sticky_o <= 1'b0;
        else if (trip)         jab_sticky_o <= 1'b1;
        else if (clr_sticky_i) jab_sticky_o <= 1'b0;
    end

    assign tx_en_o      = tx_en_i && !(blocked && mode_10bt_i);
    assign jab_active_o = blocked;
endmodule

// File: rtl/jab_checker.sv
module jab_checker #(
    parameter int RUN_LIM   = 16,
    parameter int QUIET_LIM = 16,
    parameter int RCW       = $clog2(RUN_LIM + 1),
    parameter int QCW       = $clog2(QUIET_LIM + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           tx_en_i,
    input logic           mode_10bt_i,
    input logic           jab_active_o,
    input logic           jab_sticky_o,
    input logic [RCW-1:0] run_cnt,
    input logic [QCW-1:0] quiet_cnt
);
    localparam logic [RCW-1:0] RLAST = RCW'(RUN_LIM - 1);
    localparam logic [QCW-1:0] QLAST = QCW'(QUIET_LIM - 1);

    p_trip_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_10bt_i && tx_en_i && !jab_active_o && run_cnt == RLAST) |=> jab_active_o);

    p_runclr_r2: assert property (@(posedge clk) disable iff (rst)
        !tx_en_i |=> (run_cnt == '0));

    // R3 and R4: stays tripped until the quiet count completes
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (jab_active_o && mode_10bt_i && !(!tx_en_i && quiet_cnt == QLAST)) |=> jab_active_o);

    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (jab_active_o && mode_10bt_i && tx_en_i) |=> (quiet_cnt == '0));

    p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        !mode_10bt_i |=> (run_cnt == '0 && quiet_cnt == '0 && !jab_active_o));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(jab_active_o) |-> jab_sticky_o);
endmodule

bind jabber_guard jab_checker #(.RUN_LIM(RUN_LIM), .QUIET_LIM(QUIET_LIM)) u_chk (
    .clk(clk), .rst(rst), .tx_en_i(tx_en_i), .mode_10bt_i(mode_10bt_i),
    .jab_active_o(jab_active_o), .jab_sticky_o(jab_sticky_o),
    .run_cnt(run_cnt), .quiet_cnt(quiet_cnt)
);

// File: tb/tb_jabber_guard.sv
module tb_jabber_guard;
    localparam int CLK_PERIOD = 10;
    localparam int RUN   = 6;
    localparam int QUIET = 9;

    logic clk = 1'b0;
    logic rst, tx_en, mode, clr;
    logic tx_en_o, jab_active, jab_sticky;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jabber_guard #(.RUN_LIM(RUN), .QUIET_LIM(QUIET)) dut (
        .clk(clk), .rst(rst), .tx_en_i(tx_en), .mode_10bt_i(mode),
        .clr_sticky_i(clr), .tx_en_o(tx_en_o), .jab_active_o(jab_active),
        .jab_sticky_o(jab_sticky)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // apply inputs on the falling edge and let the gate settle
    task automatic tick(input logic en, input logic md, input logic cl);
        @(negedge clk);
        tx_en = en; mode = md; clr = cl;
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        rst = 1'b0;
    endtask

    // drive high for RUN edges, then look at the result
    task automatic trip_it();
        for (int k = 0; k < RUN; k++) tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reset_r8();
        do_reset();
        tick(1'b0, 1'b1, 1'b0);
        chk("R8 active", jab_active, 1'b0);
        chk("R8 sticky", jab_sticky, 1'b0);
        chk("R8 gate", tx_en_o, 1'b0);
    endtask

    task automatic t_trip_r1();
        bit ok = 1'b1;
        do_reset();
        for (int k = 0; k < RUN; k++) begin
            tick(1'b1, 1'b1, 1'b0);
            if (tx_en_o !== 1'b1 || jab_active !== 1'b0) ok = 1'b0;
        end
        chk("R1 passes first RUN cycles", ok, 1'b1);
        tick(1'b1, 1'b1, 1'b0);
        chk("R1 gate closed", tx_en_o, 1'b0);
        chk("R1 active", jab_active, 1'b1);
        chk("R7 sticky set", jab_sticky, 1'b1);
        ok = 1'b1;
        for (int k = 0; k < 3 * RUN; k++) begin
            tick(1'b1, 1'b1, 1'b0);
            if (tx_en_o !== 1'b0 || jab_active !== 1'b1) ok = 1'b0;
        end
        chk("R3 held off while enable high", ok, 1'b1);
    endtask

    task automatic t_short_r2();
        bit ok = 1'b1;
        do_reset();
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < RUN - 1; k++) begin
                tick(1'b1, 1'b1, 1'b0);
                if (tx_en_o !== 1'b1 || jab_active !== 1'b0) ok = 1'b0;
            end
            tick(1'b0, 1'b1, 1'b0);
            if (jab_active !== 1'b0) ok = 1'b0;
        end
        chk("R2 short runs never trip", ok, 1'b1);
        chk("R2 sticky clear", jab_sticky, 1'b0);
    endtask

    task automatic t_unjab_r4();
        bit ok = 1'b1;
        do_reset();
        trip_it();
        for (int k = 0; k < QUIET; k++) begin
            tick(1'b0, 1'b1, 1'b0);
            if (jab_active !== 1'b1) ok = 1'b0;
        end
        chk("R4 tripped through quiet interval", ok, 1'b1);
        tick(1'b1, 1'b1, 1'b0);
        chk("R4 released", jab_active, 1'b0);
        chk("R4 gate open", tx_en_o, 1'b1);
    endtask

    task automatic t_restart_r5();
        bit ok = 1'b1;
        do_reset();
        trip_it();
        for (int k = 0; k < QUIET - 1; k++) tick(1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b0);
        chk("R5 blocked on early reassert", tx_en_o, 1'b0);
        for (int k = 0; k < QUIET - 1; k++) begin
            tick(1'b0, 1'b1, 1'b0);
            if (jab_active !== 1'b1) ok = 1'b0;
        end
        tick(1'b0, 1'b1, 1'b0);
        chk("R5 count restarted", ok && jab_active, 1'b1);
        tick(1'b1, 1'b1, 1'b0);
        chk("R5 released after full interval", jab_active, 1'b0);
    endtask

    task automatic t_mode_r6();
        bit ok = 1'b1;
        do_reset();
        for (int k = 0; k < 3 * RUN; k++) begin
            tick(1'b1, 1'b0, 1'b0);
            if (tx_en_o !== 1'b1 || jab_active !== 1'b0) ok = 1'b0;
        end
        chk("R6 passthrough in other mode", ok, 1'b1);
        trip_it();
        tick(1'b1, 1'b0, 1'b0);
        chk("R6 gate opens same cycle", tx_en_o, 1'b1);
        tick(1'b1, 1'b1, 1'b0);
        chk("R6 trip cleared", jab_active, 1'b0);
        chk("R6 gate open after return", tx_en_o, 1'b1);
    endtask

    task automatic t_sticky_r7();
        do_reset();
        trip_it();
        tick(1'b0, 1'b1, 1'b1);
        chk("R7 still set before edge", jab_sticky, 1'b1);
        tick(1'b0, 1'b1, 1'b0);
        chk("R7 cleared by strobe", jab_sticky, 1'b0);
        do_reset();
        for (int k = 0; k < RUN - 1; k++) tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b1);
        tick(1'b1, 1'b1, 1'b0);
        chk("R7 trip wins over clear", jab_sticky, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tx_en = 1'b0; mode = 1'b1; clr = 1'b0;
        t_reset_r8();
        t_trip_r1();
        t_short_r2();
        t_unjab_r4();
        t_restart_r5();
        t_mode_r6();
        t_sticky_r7();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule